// File: doc/BRIEF.md
# Shift-Clock Watchdog and Soft-Start Fault Supervisor

This block supervises an LED sink driver from the digital side. It watches for activity on the serial shift clock, which arrives as a one-cycle activity pulse per detected clock edge. If the controller stops clocking for a set number of system clock cycles while the watchdog is armed, every output is switched off. A thermal flag switches the outputs off in the same way, whether or not the watchdog is armed.

Once the fault is gone, and also after reset, the outputs do not come back at full strength. They come back through a soft-start ramp: a 4-bit scale factor climbs from 0 to 15, one step after each fixed number of cycles. The brightness logic downstream multiplies by this scale.

Watchdog, thermal and per-output open-circuit faults are held in sticky status bits for serial readback. A status capture strobe loads the faults present at that moment. This clears any bit whose fault has gone away and keeps any bit whose fault is still there.

Top module: `led_fault_supervisor`

## Requirements
- R1: After reset the outputs are disabled, the scale is 0, and all status bits are 0.
- R2: The ramp steps up from 0 to 15, one step after each `STEP_CYCLES` fault-free cycles, and then stays at 15. The scale never decreases while the outputs are enabled.
- R3: With the watchdog armed, `TIMEOUT` system cycles without an activity pulse clear `drv_en_o`. It falls one cycle after the idle counter reaches the limit. Any activity pulse restarts the count.
- R4: With the watchdog disarmed (`wdog_arm_i` = 0), a lack of clock activity has no effect on `drv_en_o`.
- R5: When the thermal flag is high, `drv_en_o` is 0 on the following cycle.
- R6: While `drv_en_o` is 0, the scale is 0. When the outputs come back after an activity pulse, they restart the ramp at scale 0.
- R7: The status bits (`wdog_stat_o`, `therm_stat_o`, and `open_stat_o` with bit i for output i) are set one cycle after their fault is seen. Without a capture they stay set.
- R8: On a capture strobe, each status bit is loaded with the fault's present value. Bits for faults that are gone clear, and bits for faults that are present stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_act_i | input | 1 | One-cycle pulse per detected shift-clock edge |
| wdog_arm_i | input | 1 | Watchdog enable from the control word |
| therm_hot_i | input | 1 | Over-temperature flag |
| open_flt_i | input | NUM_OUT (16) | Live open-circuit flag per output |
| stat_cap_i | input | 1 | Status capture strobe |
| drv_en_o | output | 1 | Global enable for all sink outputs |
| ss_scale_o | output | SCALE_W (4) | Soft-start scale factor |
| wdog_stat_o | output | 1 | Sticky watchdog-timeout status |
| therm_stat_o | output | 1 | Sticky thermal status |
| open_stat_o | output | NUM_OUT (16) | Sticky open-circuit status per output |

## Verification
If the idle counter is wrong, `drv_en_o` falls too early or too late compared with a bench that counts idle cycles from the last pulse. The difference shows within one cycle of the expected edge. A broken ramp counter shows up as a scale that is not at 15 once the full ramp time has passed. It also shows up as a scale that is not at 0 on the first enabled cycle after recovery. Status bits that lose their sticky behaviour, or fail to clear on capture, differ at the status ports in the very cycle after the stimulus.

// File: rtl/led_fault_pkg.sv
package led_fault_pkg;
    localparam int SCALE_W = 4;
    localparam logic [SCALE_W-1:0] SCALE_MAX = '1;
endpackage

// File: rtl/idle_timer.sv
module idle_timer #(
    parameter int TIMEOUT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic arm_i,
    output logic expired_o
);
    localparam int CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (act_i) begin
            st_d.cnt = '0;
        end else if (st_q.cnt != LIMIT) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = arm_i && (st_q.cnt == LIMIT);
endmodule

// File: rtl/soft_ramp.sv
module soft_ramp
    import led_fault_pkg::*;
#(
    parameter int STEP_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fault_i,
    output logic               en_o,
    output logic [SCALE_W-1:0] scale_o
);
    localparam int SW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [SW-1:0] STEP_LAST = SW'(STEP_CYCLES - 1);

    typedef struct packed {
        logic               en;
        logic [SCALE_W-1:0] scale;
        logic [SW-1:0]      step;
    } ramp_t;

    ramp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fault_i) begin
            st_d.en    = 1'b0;
            st_d.scale = '0;
            st_d.step  = '0;
        end else begin
            st_d.en = 1'b1;
            if (st_q.scale != SCALE_MAX) begin
                if (st_q.step == STEP_LAST) begin
                    st_d.step  = '0;
                    st_d.scale = st_q.scale + 1'b1;
                end else begin
                    st_d.step = st_q.step + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o    = st_q.en;
    assign scale_o = st_q.scale;
endmodule

// File: rtl/fault_latch.sv
module fault_latch #(
    parameter int NUM_OUT = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_i,
    input  logic               wdog_i,
    input  logic               therm_i,
    input  logic [NUM_OUT-1:0] open_i,
    output logic               wdog_o,
    output logic               therm_o,
    output logic [NUM_OUT-1:0] open_o
);
    localparam int VW = NUM_OUT + 2;

    typedef struct packed {
        logic [VW-1:0] bits;
    } lat_t;

    lat_t st_d, st_q;
    logic [VW-1:0] live;

    assign live = {wdog_i, therm_i, open_i};

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < VW; i++) begin
            st_d.bits[i] = cap_i ? live[i] : (st_q.bits[i] | live[i]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wdog_o  = st_q.bits[VW-1];
    assign therm_o = st_q.bits[VW-2];
    assign open_o  = st_q.bits[NUM_OUT-1:0];
endmodule

// File: rtl/led_fault_supervisor.sv
module led_fault_supervisor
    import led_fault_pkg::*;
#(
    parameter int TIMEOUT     = 20,
    parameter int STEP_CYCLES = 4,
    parameter int NUM_OUT     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_act_i,
    input  logic               wdog_arm_i,
    input  logic               therm_hot_i,
    input  logic [NUM_OUT-1:0] open_flt_i,
    input  logic               stat_cap_i,
    output logic               drv_en_o,
    output logic [SCALE_W-1:0] ss_scale_o,
    output logic               wdog_stat_o,
    output logic               therm_stat_o,
    output logic [NUM_OUT-1:0] open_stat_o
);
    logic wd_expired;
    logic any_fault;

    idle_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_i     (sclk_act_i),
        .arm_i     (wdog_arm_i),
        .expired_o (wd_expired)
    );

    assign any_fault = wd_expired | therm_hot_i;

    soft_ramp #(.STEP_CYCLES(STEP_CYCLES)) u_ramp (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault_i (any_fault),
        .en_o    (drv_en_o),
        .scale_o (ss_scale_o)
    );

    fault_latch #(.NUM_OUT(NUM_OUT)) u_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_i   (stat_cap_i),
        .wdog_i  (wd_expired),
        .therm_i (therm_hot_i),
        .open_i  (open_flt_i),
        .wdog_o  (wdog_stat_o),
        .therm_o (therm_stat_o),
        .open_o  (open_stat_o)
    );
endmodule

// File: rtl/led_fault_supervisor_chk.sv
module led_fault_supervisor_chk
    import led_fault_pkg::*;
#(
    parameter int NUM_OUT = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wdog_arm_i,
    input logic               therm_hot_i,
    input logic               stat_cap_i,
    input logic               drv_en_o,
    input logic [SCALE_W-1:0] ss_scale_o,
    input logic               therm_stat_o
);
    assert_therm_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot_i |=> !drv_en_o);

    assert_disarmed_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wdog_arm_i && !therm_hot_i) |=> drv_en_o);

    assert_off_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !drv_en_o |-> (ss_scale_o == '0));

    assert_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en_o && !therm_hot_i) |=> (!drv_en_o || ss_scale_o >= $past(ss_scale_o)));

    assert_therm_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        therm_hot_i |=> therm_stat_o);

    assert_therm_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_cap_i && !therm_hot_i) |=> !therm_stat_o);
endmodule

bind led_fault_supervisor led_fault_supervisor_chk #(.NUM_OUT(NUM_OUT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdog_arm_i   (wdog_arm_i),
    .therm_hot_i  (therm_hot_i),
    .stat_cap_i   (stat_cap_i),
    .drv_en_o     (drv_en_o),
    .ss_scale_o   (ss_scale_o),
    .therm_stat_o (therm_stat_o)
);

// File: tb/led_fault_supervisor_tb.sv
`timescale 1ns/1ps
module led_fault_supervisor_tb_top;
    localparam int TIMEOUT = 20;
    localparam int STEP    = 4;
    localparam int NOUT    = 16;
    localparam int NVEC    = 6;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            act = 1'b0;
    logic            arm = 1'b0;
    logic            hot = 1'b0;
    logic [NOUT-1:0] open_f = '0;
    logic            cap = 1'b0;
    logic            en;
    logic [3:0]      scale;
    logic            wd_s;
    logic            th_s;
    logic [NOUT-1:0] op_s;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    led_fault_supervisor #(.TIMEOUT(TIMEOUT), .STEP_CYCLES(STEP), .NUM_OUT(NOUT)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_act_i(act), .wdog_arm_i(arm),
        .therm_hot_i(hot), .open_flt_i(open_f), .stat_cap_i(cap),
        .drv_en_o(en), .ss_scale_o(scale), .wdog_stat_o(wd_s),
        .therm_stat_o(th_s), .open_stat_o(op_s)
    );

    // {open, hot, cap, expected open status, expected thermal status}
    localparam logic [34:0] VEC [NVEC] = '{
        {16'h0005, 1'b0, 1'b0, 16'h0005, 1'b0},
        {16'h0000, 1'b0, 1'b0, 16'h0005, 1'b0},
        {16'h8000, 1'b0, 1'b0, 16'h8005, 1'b0},
        {16'h8000, 1'b0, 1'b1, 16'h8000, 1'b0},
        {16'h0000, 1'b1, 1'b0, 16'h8000, 1'b1},
        {16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_act();
        act = 1'b1;
        tick(1);
        act = 1'b0;
    endtask

    task automatic pulse_cap();
        cap = 1'b1;
        tick(1);
        cap = 1'b0;
    endtask

    initial begin
        tick(2);
        chk("R1 en", 32'(en), 0);
        chk("R1 scale", 32'(scale), 0);
        chk("R1 status", 32'({wd_s, th_s, op_s}), 0);
        rst_n = 1'b1;
        tick(30);
        chk("R2 mid-ramp scale nonzero", 32'(scale != 0), 1);
        chk("R2 mid-ramp scale below max", 32'(scale != 4'hF), 1);
        tick(40);
        chk("R2 full scale", 32'(scale), 15);
        tick(10);
        chk("R2 held at max", 32'(scale), 15);
        chk("R4 disarmed idle en", 32'(en), 1);

        for (int i = 0; i < NVEC; i++) begin
            open_f = VEC[i][34:19];
            hot    = VEC[i][18];
            cap    = VEC[i][17];
            tick(1);
            chk("R7/R8 vector open status", 32'(op_s), 32'(VEC[i][16:1]));
            chk("R7/R8 vector thermal status", 32'(th_s), 32'(VEC[i][0]));
        end
        open_f = '0; hot = 1'b0; cap = 1'b0;
        tick(70);

        arm = 1'b1;
        for (int k = 0; k < 12; k++) begin
            pulse_act();
            tick(TIMEOUT - 5);
        end
        chk("R3 keepalive en", 32'(en), 1);
        pulse_act();
        tick(TIMEOUT - 1);
        chk("R3 before limit en", 32'(en), 1);
        tick(3);
        chk("R3 after limit en", 32'(en), 0);
        chk("R6 off scale", 32'(scale), 0);
        chk("R7 wd status", 32'(wd_s), 1);
        pulse_act();
        tick(1);
        chk("R6 recovered en", 32'(en), 1);
        chk("R6 recovery restart scale", 32'(scale), 0);
        chk("R7 wd status sticky", 32'(wd_s), 1);
        pulse_cap();
        chk("R8 wd status cleared", 32'(wd_s), 0);

        arm = 1'b0;
        hot = 1'b1;
        tick(1);
        chk("R5 hot en", 32'(en), 0);
        hot = 1'b0;
        tick(2);
        chk("R5 cool en", 32'(en), 1);
        chk("R7 therm sticky", 32'(th_s), 1);
        hot = 1'b1;
        pulse_cap();
        chk("R8 capture keeps present fault", 32'(th_s), 1);
        hot = 1'b0;
        tick(2 * TIMEOUT);
        chk("R4 disarmed long idle en", 32'(en), 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog timer expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end
endmodule